// File: doc/BRIEF.md
# Segmented Min-Sum Check-Node Relay Chain

This block performs the min-sum check-node update for one parity-check row of a low-density parity-check decoder. The row's edges are divided evenly among a chain of segments, each owning a contiguous run of edge positions. Every segment reduces its own signed log-likelihood ratios to a sign parity, the smallest and second-smallest magnitudes and the row position of the smallest. It merges that local summary with the partial summary handed over by its left neighbour and passes the result only to its right neighbour. There is no shared bus across the chain.

The last segment's summary, together with each edge's own sign, yields the per-edge results. An edge gets the minimum of all other magnitudes and the XOR of all other signs. A whole row is presented on one cycle. A new row may enter on every cycle, so rows from several interleaved codeword streams, each marked by a small tag, move down the chain at once without stalls. The default configuration has four segments of five edges, a 20-edge row, and five cycles per segment.

Top module: `minsum_relay_chain`

## Requirements
- R1: For every edge of a valid output row, `out_mag` equals the smallest saturated magnitude among the other 19 edges of that row.
- R2: For every edge, `out_sign` equals the XOR of the sign bits of the other 19 edges. A sign bit is bit 5 of the 6-bit two's-complement input, so 1 means negative.
- R3: The magnitude of an input is its absolute value saturated to 31, so the input -32 counts as magnitude 31.
- R4: When the smallest magnitude occurs on two or more edges, possibly in different segments, every edge of the row receives that magnitude.
- R5: A row presented with `in_valid` high at a rising edge appears on the outputs with `out_valid` high exactly 20 cycles later, after the 20th following rising edge.
- R6: `out_tag` of an output row equals the `in_tag` given with that row.
- R7: Rows may be presented on consecutive cycles with no gap. All are accepted, and they leave in the order they entered with no stall.
- R8: `out_valid` is low during and after reset until a row has passed the chain, and it is low on every cycle that has no row due.
- R9: In any valid output row, at most one edge carries a magnitude above the row's smallest output magnitude.
- R10: An input of zero counts as magnitude 0 with a positive sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A row is presented this cycle |
| in_tag | input | 2 | Stream tag of the presented row |
| in_llr | input | 120 | 20 six-bit two's-complement LLRs; edge e in bits [6e+5:6e] |
| out_valid | output | 1 | A finished row is on the outputs |
| out_tag | output | 2 | Stream tag of the finished row |
| out_sign | output | 20 | Per-edge output sign, edge e in bit e, 1 means negative |
| out_mag | output | 100 | Per-edge output magnitude, edge e in bits [5e+4:5e] |

## Verification
Every row's result is due 20 rising edges after the edge that takes it in: five register stages in each of the four segments, with the outputs read straight from the last stage. The bench records the cycle count when it drives a row. It samples the outputs on falling edges and requires each output row to arrive exactly 20 counted edges later, in entry order. It also requires `out_valid` to stay low whenever no row is due. The reference values are computed per edge as the minimum and sign parity over the other edges directly. The design's two-minimum shortcut is not used in the bench.

// File: rtl/minsum_relay_pkg.sv
package minsum_relay_pkg;
  localparam int LLR_W   = 6;
  localparam int MAG_W   = LLR_W - 1;
  localparam int IDX_W   = 5;
  localparam int TAG_W   = 2;
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

  typedef struct packed {
    logic [MAG_W-1:0] m1;
    logic [MAG_W-1:0] m2;
    logic [IDX_W-1:0] idx;
    logic             sgn;
  } relay_t;

  // saturating absolute value; most negative code maps to MAG_MAX
  function automatic logic [MAG_W-1:0] sat_mag(input logic [LLR_W-1:0] x);
    logic [LLR_W-1:0] neg;
    neg = ~x + 1'b1;
    if (!x[LLR_W-1])                         return x[MAG_W-1:0];
    else if (x == {1'b1, {MAG_W{1'b0}}})     return MAG_MAX;
    else                                     return neg[MAG_W-1:0];
  endfunction

  // combine left-neighbour summary (earlier edges) with a local one;
  // strict compare keeps the earlier edge as min1 on a tie
  function automatic relay_t merge(input relay_t left, input relay_t loc);
    relay_t r;
    r.sgn = left.sgn ^ loc.sgn;
    if (loc.m1 < left.m1) begin
      r.m1  = loc.m1;
      r.idx = loc.idx;
      r.m2  = (left.m1 < loc.m2) ? left.m1 : loc.m2;
    end else begin
      r.m1  = left.m1;
      r.idx = left.idx;
      r.m2  = (loc.m1 < left.m2) ? loc.m1 : left.m2;
    end
    return r;
  endfunction
endpackage

// File: rtl/minsum_relay_dly.sv
module minsum_relay_dly #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (D == 0) begin : g_pass
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] r_q [D];
      always_ff @(posedge clk) begin
        r_q[0] <= d;
        for (int i = 1; i < D; i++) r_q[i] <= r_q[i-1];
      end
      assign q = r_q[D-1];
    end
  endgenerate
endmodule

// File: rtl/minsum_relay_seg.sv
module minsum_relay_seg
  import minsum_relay_pkg::*;
#(
  parameter int EPS     = 5,
  parameter int BASE    = 0,
  parameter int SEG_LAT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 up_valid,
  input  logic [TAG_W-1:0]     up_tag,
  input  relay_t               up_word,
  input  logic [EPS*LLR_W-1:0] slice,
  output logic                 dn_valid,
  output logic [TAG_W-1:0]     dn_tag,
  output relay_t               dn_word
);
  relay_t           loc;
  relay_t           nxt;
  logic             v_q [SEG_LAT];
  logic [TAG_W-1:0] t_q [SEG_LAT];
  relay_t           w_q [SEG_LAT];

  // local two-minimum search over this segment's edges, then merge
  always_comb begin
    loc = '{m1: MAG_MAX, m2: MAG_MAX, idx: '0, sgn: 1'b0};
    for (int i = 0; i < EPS; i++) begin
      logic [LLR_W-1:0] l;
      logic [MAG_W-1:0] m;
      l = slice[i*LLR_W +: LLR_W];
      m = sat_mag(l);
      loc.sgn = loc.sgn ^ l[LLR_W-1];
      if (m < loc.m1) begin
        loc.m2  = loc.m1;
        loc.m1  = m;
        loc.idx = IDX_W'(BASE + i);
      end else if (m < loc.m2) begin
        loc.m2 = m;
      end
    end
    nxt = merge(up_word, loc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_LAT; i++) v_q[i] <= 1'b0;
    end else begin
      v_q[0] <= up_valid;
      for (int i = 1; i < SEG_LAT; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid) begin
      w_q[0] <= nxt;
      t_q[0] <= up_tag;
    end
    for (int i = 1; i < SEG_LAT; i++) begin
      if (v_q[i-1]) begin
        w_q[i] <= w_q[i-1];
        t_q[i] <= t_q[i-1];
      end
    end
  end

  assign dn_valid = v_q[SEG_LAT-1];
  assign dn_tag   = t_q[SEG_LAT-1];
  assign dn_word  = w_q[SEG_LAT-1];
endmodule

// File: rtl/minsum_relay_chain.sv
module minsum_relay_chain
  import minsum_relay_pkg::*;
#(
  parameter int NSEG    = 4,
  parameter int EPS     = 5,
  parameter int SEG_LAT = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [TAG_W-1:0]             in_tag,
  input  logic [NSEG*EPS*LLR_W-1:0]    in_llr,
  output logic                         out_valid,
  output logic [TAG_W-1:0]             out_tag,
  output logic [NSEG*EPS-1:0]          out_sign,
  output logic [NSEG*EPS*MAG_W-1:0]    out_mag
);
  localparam int ROW   = NSEG * EPS;
  localparam int LAT   = NSEG * SEG_LAT;
  localparam int SLC_W = EPS * LLR_W;

  logic             ch_v [NSEG+1];
  logic [TAG_W-1:0] ch_t [NSEG+1];
  relay_t           ch_w [NSEG+1];
  logic [ROW-1:0]   sgn_in;
  logic [ROW-1:0]   sgn_dly;

  assign ch_v[0] = in_valid;
  assign ch_t[0] = in_tag;
  assign ch_w[0] = '{m1: MAG_MAX, m2: MAG_MAX, idx: '0, sgn: 1'b0};

  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic [SLC_W-1:0] slice_al;
      // skew each slice so it meets the relay word at its segment
      minsum_relay_dly #(.W(SLC_W), .D(g*SEG_LAT)) u_skew (
        .clk (clk),
        .d   (in_llr[g*SLC_W +: SLC_W]),
        .q   (slice_al)
      );
      minsum_relay_seg #(.EPS(EPS), .BASE(g*EPS), .SEG_LAT(SEG_LAT)) u_seg (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (ch_v[g]),
        .up_tag   (ch_t[g]),
        .up_word  (ch_w[g]),
        .slice    (slice_al),
        .dn_valid (ch_v[g+1]),
        .dn_tag   (ch_t[g+1]),
        .dn_word  (ch_w[g+1])
      );
    end
    for (genvar e = 0; e < ROW; e++) begin : g_sgn
      assign sgn_in[e] = in_llr[e*LLR_W + LLR_W-1];
    end
  endgenerate

  minsum_relay_dly #(.W(ROW), .D(LAT)) u_sgn_dly (
    .clk (clk),
    .d   (sgn_in),
    .q   (sgn_dly)
  );

  always_comb begin
    out_valid = ch_v[NSEG];
    out_tag   = ch_t[NSEG];
    for (int e = 0; e < ROW; e++) begin
      out_sign[e] = ch_w[NSEG].sgn ^ sgn_dly[e];
      out_mag[e*MAG_W +: MAG_W] = (ch_w[NSEG].idx == IDX_W'(e)) ? ch_w[NSEG].m2
                                                                 : ch_w[NSEG].m1;
    end
  end
endmodule

// File: rtl/minsum_relay_chain_chk.sv
module minsum_relay_chain_chk
  import minsum_relay_pkg::*;
#(
  parameter int ROW = 20,
  parameter int LAT = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic [TAG_W-1:0]       out_tag,
  input logic [ROW*MAG_W-1:0]   out_mag
);
  localparam int CW = $clog2(LAT + 2) + 1;

  logic [CW-1:0]    pend_q, pend_n;
  logic [CW-1:0]    age_q, age_n;
  logic [MAG_W-1:0] lo;
  int               n_above;

  always_comb begin
    pend_n = pend_q + CW'(in_valid) - CW'(out_valid);
    age_n  = (age_q < CW'(LAT)) ? age_q + 1'b1 : age_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      age_q  <= '0;
    end else begin
      pend_q <= pend_n;
      age_q  <= age_n;
    end
  end

  always_comb begin
    lo = MAG_MAX;
    for (int e = 0; e < ROW; e++)
      if (out_mag[e*MAG_W +: MAG_W] < lo) lo = out_mag[e*MAG_W +: MAG_W];
    n_above = 0;
    for (int e = 0; e < ROW; e++)
      if (out_mag[e*MAG_W +: MAG_W] > lo) n_above = n_above + 1;
  end

  assert_single_outlier_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (n_above <= 1));

  assert_no_early_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q < CW'(LAT)) |-> !out_valid);

  assert_no_phantom_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pend_q != '0));

  assert_no_overfill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= CW'(LAT));

  assert_tag_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_tag));
endmodule

bind minsum_relay_chain minsum_relay_chain_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_tag   (out_tag),
  .out_mag   (out_mag)
);

// File: tb/minsum_relay_chain_test.sv
module minsum_relay_chain_test;
  localparam int ROW = 20;
  localparam int LAT = 20;
  localparam int MAXR = 256;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [1:0]       in_tag;
  logic [ROW*6-1:0] in_llr;
  logic             out_valid;
  logic [1:0]       out_tag;
  logic [ROW-1:0]   out_sign;
  logic [ROW*5-1:0] out_mag;

  minsum_relay_chain uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_llr(in_llr), .out_valid(out_valid), .out_tag(out_tag),
    .out_sign(out_sign), .out_mag(out_mag)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int wr    = 0;
  int rd    = 0;
  int cur [ROW];

  logic [ROW-1:0]   e_sign [MAXR];
  logic [ROW*5-1:0] e_mag  [MAXR];
  logic [1:0]       e_tag  [MAXR];
  int               e_cyc  [MAXR];
  string            e_lbl  [MAXR];

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int mag_of(input int v);
    if (v < 0) return (v == -32) ? 31 : -v;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive the row held in cur[] for one cycle and record its expected result
  task automatic send(input logic [1:0] tag, input string lbl);
    @(negedge clk);
    for (int e = 0; e < ROW; e++) in_llr[e*6 +: 6] = 6'(cur[e]);
    in_tag   = tag;
    in_valid = 1'b1;
    for (int e = 0; e < ROW; e++) begin
      int mn = 99;
      bit sx = 1'b0;
      for (int j = 0; j < ROW; j++) begin
        if (j != e) begin
          if (mag_of(cur[j]) < mn) mn = mag_of(cur[j]);
          sx ^= (cur[j] < 0);
        end
      end
      e_mag[wr][e*5 +: 5] = 5'(mn);
      e_sign[wr][e]       = sx;
    end
    e_tag[wr] = tag;
    e_cyc[wr] = cyc;
    e_lbl[wr] = lbl;
    wr++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_llr   = '0;
    end
  endtask

  // output monitor, sampling away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (rd >= wr) begin
          check(1'b0, "R8", "row with none due", 128'(out_valid), 128'(0));
        end else begin
          check(cyc - e_cyc[rd] == LAT, "R5 R7", "latency/order",
                128'(cyc - e_cyc[rd]), 128'(LAT));
          check(out_tag == e_tag[rd], "R6", "tag", 128'(out_tag), 128'(e_tag[rd]));
          check(out_mag == e_mag[rd], {"R1 ", e_lbl[rd]}, "magnitudes",
                128'(out_mag), 128'(e_mag[rd]));
          check(out_sign == e_sign[rd], {"R2 ", e_lbl[rd]}, "signs",
                128'(out_sign), 128'(e_sign[rd]));
          rd++;
        end
      end else if (rd < wr && cyc - e_cyc[rd] >= LAT) begin
        check(1'b0, "R5 R7", "missing row", 128'(cyc - e_cyc[rd]), 128'(LAT));
        rd++;
      end
    end
  end

  initial begin
    int wd;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_tag   = '0;
    in_llr   = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "valid in reset", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R8", "valid after reset", 128'(out_valid), 128'(0));

    // R4: all edges tied
    for (int e = 0; e < ROW; e++) cur[e] = 7;
    send(2'd0, "R4 all tied");
    // R1: unique minimum on the last edge
    for (int e = 0; e < ROW; e++) cur[e] = 20;
    cur[0] = 4; cur[19] = -3;
    send(2'd1, "R1 min on last edge");
    // R3: most negative code saturates
    for (int e = 0; e < ROW; e++) cur[e] = 31;
    cur[5] = -32;
    send(2'd2, "R3 saturation");
    // R10: zero input is positive, magnitude 0
    for (int e = 0; e < ROW; e++) cur[e] = -5;
    cur[0] = 0;
    send(2'd3, "R10 zero input");
    // R4: tie across segments
    for (int e = 0; e < ROW; e++) cur[e] = 9 + (e % 7);
    cur[3] = -2; cur[17] = 2;
    send(2'd0, "R4 tie across segments");
    // R3: several -32 with one small
    for (int e = 0; e < ROW; e++) cur[e] = -32;
    cur[11] = 1;
    send(2'd1, "R3 many saturated");
    idle(LAT + 2);
    check(out_valid == 1'b0 && rd == wr, "R8", "drained", 128'(rd), 128'(wr));

    // R7: back-to-back random rows, four interleaved tags
    for (int k = 0; k < 160; k++) begin
      for (int e = 0; e < ROW; e++) cur[e] = int'($urandom_range(63)) - 32;
      send(2'(k % 4), "R7 back-to-back");
    end
    // random rows with idle gaps
    for (int k = 0; k < 40; k++) begin
      for (int e = 0; e < ROW; e++) cur[e] = int'($urandom_range(15)) - 8;
      send(2'($urandom_range(3)), "R7 gapped");
      idle(int'($urandom_range(3)));
    end
    idle(1);

    wd = 0;
    while (rd < wr && wd < 2000) begin
      @(negedge clk);
      wd++;
    end
    if (rd < wr) check(1'b0, "R7", "watchdog expired", 128'(rd), 128'(wr));
    idle(5);
    check(out_valid == 1'b0, "R8", "idle after drain", 128'(out_valid), 128'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule